// File: doc/BRIEF.md
# Uncore Event Counter Unit

This block is a memory-mapped performance monitoring unit holding eight 64-bit event counters. A vector of single-cycle event pulses, one bit per 8-bit event code, comes from the surrounding fabric. Each counter picks one code through a select byte and adds one for every pulse of that code. A counter advances only while the unit is running and its own enable bit is set. Software reaches every register through a single-cycle register bus with a 64-bit data path. Counters are read and written as whole 64-bit words at any time.

A counter that wraps from all ones to zero sets its bit in an overflow status register. The interrupt output is raised for any status bit whose mask bit is clear. The clearing style is chosen by a parameter. In the split style a separate register clears status bits when written with ones. In the self-clearing style, writing ones to the status register itself clears them. Two ID filters and a trace-tag gate qualify every pulse. Each ID filter compares a transaction attribute with a command under a don't-care mask.

The run control is a two-state machine. HALT is the reset state, in which no counter advances. The GO transition, a control write with bit 0 set, moves it to RUN. In RUN the enabled counters advance. The STOP transition, a control write with bit 0 clear, moves it back to HALT.

Top module: `evc_unit`

## Requirements
- R1: After reset every counter, the control register, the counter-enable register, the filters and the status register read 0. The mask register reads all ones (0xFF), and the interrupt output is low.
- R2: Counters 0..3 take their event code from the select register at offset 0x040 and counters 4..7 from offset 0x044. Counter i uses bits 8*(i mod 4)+7 : 8*(i mod 4). A counter adds one only on a pulse of evt_pulse[code].
- R3: A counter advances only while the state machine is in RUN and bit i of the counter-enable register (offset 0x004) is set. RUN is entered by a write with bit 0 set to offset 0x000; a write with bit 0 clear returns to HALT, which is read back as bit 0.
- R4: Counter i is read and written as one 64-bit word at offset 0x100 + 8*i. A software write landing in the same cycle as an increment wins.
- R5: An increment of a counter holding all ones makes it read 0 and sets bit i of the status register (offset 0x024) on the same edge.
- R6: The interrupt output is high exactly when some status bit is set whose bit in the mask register (offset 0x020, 1 = masked) is 0.
- R7: In the split style (CLR_STYLE=0), writing 1 to bit i at offset 0x028 clears status bit i, and writes to the status register have no effect. In the self-clearing style (CLR_STYLE=1), writing 1 to bit i of the status register clears it. A new overflow in the same cycle wins over a clear.
- R8: The source filter (offset 0x010) and target filter (offset 0x00C) hold a command in bits 10:0, an enable in bit 11 and a mask in bits 22:12. An enabled filter passes a pulse only if ((id XOR command) AND NOT mask) is 0. Writing 0 disables the filter.
- R9: When bit 4 of the trace-tag register (offset 0x008) is set, only pulses arriving with txn_tag high are counted.
- R10: The identifier register at offset 0x07C reads VERSION_ID, and writes to it are ignored.
- R11: A read strobe captures the addressed value on the clock edge, and bus_rdata then holds it until the next read. Unmapped offsets and the clear register read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 64 | Write data; non-counter registers use the low 32 bits |
| bus_rdata | output | 64 | Registered read data |
| evt_pulse | input | 256 | One pulse bit per event code |
| txn_src_id | input | 11 | Source ID of the pulsed transaction |
| txn_tgt_id | input | 11 | Target ID of the pulsed transaction |
| txn_tag | input | 1 | Trace tag of the pulsed transaction |
| irq | output | 1 | Unmasked overflow interrupt |

## Verification
Several results are due one edge after their stimulus. A write or an event pulse changes a counter, a register or the status on the edge that samples it. The interrupt follows that status combinationally in the same cycle, and read data appears on the edge that samples the read strobe. The bench therefore drives strobes and pulses at the falling edge, so that exactly one rising edge acts on them. It samples the interrupt and the read data at the following falling edge. The write-priority and wrap cases place the write and the pulse on the same rising edge, or step a counter edge by edge, before reading it back.

// File: rtl/evc_pkg.sv
package evc_pkg;
    localparam int unsigned OFF_CTRL  = 'h000;
    localparam int unsigned OFF_CEN   = 'h004;
    localparam int unsigned OFF_TAG   = 'h008;
    localparam int unsigned OFF_TGTF  = 'h00C;
    localparam int unsigned OFF_SRCF  = 'h010;
    localparam int unsigned OFF_MASK  = 'h020;
    localparam int unsigned OFF_STAT  = 'h024;
    localparam int unsigned OFF_CLR   = 'h028;
    localparam int unsigned OFF_SEL   = 'h040;
    localparam int unsigned OFF_VER   = 'h07C;
    localparam int unsigned OFF_CNT   = 'h100;
    localparam int unsigned SEL_W     = 32;
    localparam int unsigned TAG_BIT   = 4;

    typedef enum logic {
        ST_HALT = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;
endpackage

// File: rtl/evc_counter.sv
module evc_counter #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_i,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] cnt_o,
    output logic         ovf_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (wr_i)
            cnt_q <= wdata_i;
        else if (inc_i)
            cnt_q <= cnt_q + 1'b1;
    end

    assign ovf_o = inc_i && !wr_i && (&cnt_q);
    assign cnt_o = cnt_q;

    // R3: no increment and no write leaves the count unchanged
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc_i && !wr_i) |=> $stable(cnt_q));

    // R4: a write wins over a same-cycle increment
    a_r4_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (cnt_q == $past(wdata_i)));
endmodule

// File: rtl/evc_filter.sv
module evc_filter #(
    parameter int ID_W = 11,
    localparam int CFG_W = 2 * ID_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] src_cfg_i,
    input  logic [CFG_W-1:0] tgt_cfg_i,
    input  logic             tag_en_i,
    input  logic [ID_W-1:0]  src_id_i,
    input  logic [ID_W-1:0]  tgt_id_i,
    input  logic             tag_i,
    output logic             pass_o
);
    logic src_ok, tgt_ok, tag_ok;

    function automatic logic id_match(input logic [CFG_W-1:0] cfg,
                                      input logic [ID_W-1:0] id);
        logic [ID_W-1:0] cmd, dc;
        cmd = cfg[ID_W-1:0];
        dc  = cfg[CFG_W-1:ID_W+1];
        return !cfg[ID_W] || (((id ^ cmd) & ~dc) == '0);
    endfunction

    assign src_ok = id_match(src_cfg_i, src_id_i);
    assign tgt_ok = id_match(tgt_cfg_i, tgt_id_i);
    assign tag_ok = !tag_en_i || tag_i;
    assign pass_o = src_ok && tgt_ok && tag_ok;

    // R8: an enabled source filter with no don't-care bits passes only an exact match
    a_r8_exact: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_o && src_cfg_i[ID_W] && (src_cfg_i[CFG_W-1:ID_W+1] == '0))
            |-> (src_id_i == src_cfg_i[ID_W-1:0]));
endmodule

// File: rtl/evc_regs.sv
module evc_regs
    import evc_pkg::*;
#(
    parameter int          NUM_CNT   = 8,
    parameter int          CNT_W     = 64,
    parameter int          ADDR_W    = 12,
    parameter int          ID_W      = 11,
    parameter int          NUM_SEL   = 2,
    parameter int          CLR_STYLE = 0,
    parameter logic [31:0] VERSION_ID = 32'h0000_0B17,
    localparam int         CFG_W     = 2 * ID_W + 1
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                bus_we,
    input  logic                                bus_re,
    input  logic [ADDR_W-1:0]                   bus_addr,
    input  logic [CNT_W-1:0]                    bus_wdata,
    output logic [CNT_W-1:0]                    bus_rdata,
    input  logic [NUM_CNT-1:0][CNT_W-1:0]       cnt_i,
    input  logic [NUM_CNT-1:0]                  ovf_i,
    output logic [NUM_CNT-1:0]                  cnt_wr_o,
    output logic                                run_o,
    output logic [NUM_CNT-1:0]                  cnt_en_o,
    output logic [NUM_SEL-1:0][SEL_W-1:0]       sel_o,
    output logic [CFG_W-1:0]                    src_cfg_o,
    output logic [CFG_W-1:0]                    tgt_cfg_o,
    output logic                                tag_en_o,
    output logic [NUM_CNT-1:0]                  mask_o,
    output logic [NUM_CNT-1:0]                  stat_o
);
    run_state_e                      state_q, state_d;
    logic [NUM_CNT-1:0]              cen_q, mask_q, stat_q, clr_v;
    logic [NUM_SEL-1:0][SEL_W-1:0]   sel_q;
    logic [CFG_W-1:0]                srcf_q, tgtf_q;
    logic                            tag_q;
    logic [CNT_W-1:0]                rd_val;
    logic                            wr_ctrl;

    function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned off);
        return a == ADDR_W'(off);
    endfunction

    assign wr_ctrl = bus_we && hit(bus_addr, OFF_CTRL);

    // Run-control state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    // Transitions: GO (HALT -> RUN), STOP (RUN -> HALT)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: if (wr_ctrl && bus_wdata[0])  state_d = ST_RUN;
            ST_RUN:  if (wr_ctrl && !bus_wdata[0]) state_d = ST_HALT;
        endcase
    end

    // Output process of the state machine
    always_comb begin
        run_o = (state_q == ST_RUN);
    end

    // Configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cen_q  <= '0;
            mask_q <= '1;
            sel_q  <= '0;
            srcf_q <= '0;
            tgtf_q <= '0;
            tag_q  <= 1'b0;
        end else if (bus_we) begin
            if (hit(bus_addr, OFF_CEN))  cen_q  <= bus_wdata[NUM_CNT-1:0];
            if (hit(bus_addr, OFF_MASK)) mask_q <= bus_wdata[NUM_CNT-1:0];
            if (hit(bus_addr, OFF_SRCF)) srcf_q <= bus_wdata[CFG_W-1:0];
            if (hit(bus_addr, OFF_TGTF)) tgtf_q <= bus_wdata[CFG_W-1:0];
            if (hit(bus_addr, OFF_TAG))  tag_q  <= bus_wdata[TAG_BIT];
            for (int k = 0; k < NUM_SEL; k++)
                if (hit(bus_addr, OFF_SEL + 4 * k)) sel_q[k] <= bus_wdata[SEL_W-1:0];
        end
    end

    // Clear-style variant
    generate
        if (CLR_STYLE == 0) begin : g_split_clr
            assign clr_v = (bus_we && hit(bus_addr, OFF_CLR)) ? bus_wdata[NUM_CNT-1:0] : '0;
        end else begin : g_self_clr
            assign clr_v = (bus_we && hit(bus_addr, OFF_STAT)) ? bus_wdata[NUM_CNT-1:0] : '0;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr_v) | ovf_i;
    end

    // Counter write decode
    generate
        for (genvar i = 0; i < NUM_CNT; i++) begin : g_wr
            assign cnt_wr_o[i] = bus_we && hit(bus_addr, OFF_CNT + 8 * i);
        end
    endgenerate

    // Read mux
    always_comb begin
        rd_val = '0;
        if (hit(bus_addr, OFF_CTRL)) rd_val[0]           = run_o;
        if (hit(bus_addr, OFF_CEN))  rd_val[NUM_CNT-1:0] = cen_q;
        if (hit(bus_addr, OFF_TAG))  rd_val[TAG_BIT]     = tag_q;
        if (hit(bus_addr, OFF_SRCF)) rd_val[CFG_W-1:0]   = srcf_q;
        if (hit(bus_addr, OFF_TGTF)) rd_val[CFG_W-1:0]   = tgtf_q;
        if (hit(bus_addr, OFF_MASK)) rd_val[NUM_CNT-1:0] = mask_q;
        if (hit(bus_addr, OFF_STAT)) rd_val[NUM_CNT-1:0] = stat_q;
        if (hit(bus_addr, OFF_VER))  rd_val[31:0]        = VERSION_ID;
        for (int k = 0; k < NUM_SEL; k++)
            if (hit(bus_addr, OFF_SEL + 4 * k)) rd_val[SEL_W-1:0] = sel_q[k];
        for (int i = 0; i < NUM_CNT; i++)
            if (hit(bus_addr, OFF_CNT + 8 * i)) rd_val = cnt_i[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_re) bus_rdata <= rd_val;
    end

    assign cnt_en_o  = cen_q;
    assign sel_o     = sel_q;
    assign src_cfg_o = srcf_q;
    assign tgt_cfg_o = tgtf_q;
    assign tag_en_o  = tag_q;
    assign mask_o    = mask_q;
    assign stat_o    = stat_q;

    // R5: an overflow pulse leaves its status bit set
    a_r5_ovf_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_i != '0) |=> ((stat_q & $past(ovf_i)) == $past(ovf_i)));

    // R7: a clear without a same-cycle overflow leaves those bits clear
    a_r7_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_v & ~ovf_i) != '0) |=> ((stat_q & $past(clr_v & ~ovf_i)) == '0));
endmodule

// File: rtl/evc_unit.sv
module evc_unit
    import evc_pkg::*;
#(
    parameter int          NUM_CNT    = 8,
    parameter int          CNT_W      = 64,
    parameter int          CODE_W     = 8,
    parameter int          ID_W       = 11,
    parameter int          ADDR_W     = 12,
    parameter int          CLR_STYLE  = 0,
    parameter logic [31:0] VERSION_ID = 32'h0000_0B17,
    localparam int         NUM_EVT    = 1 << CODE_W,
    localparam int         LANES      = SEL_W / CODE_W,
    localparam int         NUM_SEL    = (NUM_CNT + LANES - 1) / LANES,
    localparam int         CFG_W      = 2 * ID_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_we,
    input  logic               bus_re,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [CNT_W-1:0]   bus_wdata,
    output logic [CNT_W-1:0]   bus_rdata,
    input  logic [NUM_EVT-1:0] evt_pulse,
    input  logic [ID_W-1:0]    txn_src_id,
    input  logic [ID_W-1:0]    txn_tgt_id,
    input  logic               txn_tag,
    output logic               irq
);
    logic [NUM_CNT-1:0][CNT_W-1:0]  cnt;
    logic [NUM_CNT-1:0]             ovf, inc, cnt_wr, cnt_en, mask, stat;
    logic [NUM_SEL-1:0][SEL_W-1:0]  sel;
    logic [CFG_W-1:0]               src_cfg, tgt_cfg;
    logic                           tag_en, run, pass;
    logic [NUM_EVT-1:0]             evt_ok;

    evc_regs #(
        .NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .ID_W(ID_W),
        .NUM_SEL(NUM_SEL), .CLR_STYLE(CLR_STYLE), .VERSION_ID(VERSION_ID)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cnt_i(cnt), .ovf_i(ovf), .cnt_wr_o(cnt_wr),
        .run_o(run), .cnt_en_o(cnt_en), .sel_o(sel),
        .src_cfg_o(src_cfg), .tgt_cfg_o(tgt_cfg), .tag_en_o(tag_en),
        .mask_o(mask), .stat_o(stat)
    );

    evc_filter #(.ID_W(ID_W)) u_filt (
        .clk(clk), .rst_n(rst_n),
        .src_cfg_i(src_cfg), .tgt_cfg_i(tgt_cfg), .tag_en_i(tag_en),
        .src_id_i(txn_src_id), .tgt_id_i(txn_tgt_id), .tag_i(txn_tag),
        .pass_o(pass)
    );

    assign evt_ok = evt_pulse & {NUM_EVT{pass}};

    generate
        for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
            localparam int SEL_IDX = i / LANES;
            localparam int LANE    = i % LANES;
            logic [CODE_W-1:0] code;
            assign code   = sel[SEL_IDX][LANE*CODE_W +: CODE_W];
            assign inc[i] = run && cnt_en[i] && evt_ok[code];

            evc_counter #(.W(CNT_W)) u_cnt (
                .clk(clk), .rst_n(rst_n),
                .inc_i(inc[i]), .wr_i(cnt_wr[i]), .wdata_i(bus_wdata),
                .cnt_o(cnt[i]), .ovf_o(ovf[i])
            );
        end
    endgenerate

    assign irq = |(stat & ~mask);

    // R6: with every source masked the interrupt stays low
    a_r6_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '1) |-> !irq);

    // R3: in HALT no counter overflows
    a_r3_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (ovf == '0));
endmodule

// File: tb/sim_evc_unit.sv
module sim_evc_unit;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_we = 1'b0, bus_re = 1'b0;
    logic [11:0]  bus_addr = '0;
    logic [63:0]  bus_wdata = '0;
    logic [63:0]  rdata0, rdata1;
    logic [255:0] evt = '0;
    logic [10:0]  src_id = '0, tgt_id = '0;
    logic         tag = 1'b0;
    logic         irq0, irq1;
    int           n_checks = 0, n_errors = 0;

    always #2.5 clk = ~clk;

    evc_unit #(.CLR_STYLE(0)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata0),
        .evt_pulse(evt), .txn_src_id(src_id), .txn_tgt_id(tgt_id),
        .txn_tag(tag), .irq(irq0));

    evc_unit #(.CLR_STYLE(1)) u1 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata1),
        .evt_pulse(evt), .txn_src_id(src_id), .txn_tgt_id(tgt_id),
        .txn_tag(tag), .irq(irq1));

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [63:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [63:0] d0, output logic [63:0] d1);
        @(negedge clk);
        bus_re = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_re = 1'b0;
        d0 = rdata0; d1 = rdata1;
    endtask

    task automatic pulse(input int code, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); evt[code] = 1'b1;
            @(negedge clk); evt[code] = 1'b0;
        end
    endtask

    function automatic logic [11:0] cnt_off(input int i);
        return 12'(12'h100 + 8 * i);
    endfunction

    task automatic t_reset();
        logic [63:0] a, b;
        rd(12'h000, a, b); chk("R1 ctrl", a, 0);
        rd(12'h004, a, b); chk("R1 cnt enable", a, 0);
        rd(12'h020, a, b); chk("R1 mask", a, 64'hFF);
        rd(12'h024, a, b); chk("R1 status", a, 0);
        rd(12'h010, a, b); chk("R1 src filter", a, 0);
        rd(cnt_off(5), a, b); chk("R1 counter5", a, 0);
        chk("R1 irq", {63'b0, irq0}, 0);
    endtask

    task automatic t_select();
        logic [63:0] a, b;
        wr(12'h040, 64'h4433_2211);
        wr(12'h044, 64'h8877_6655);
        wr(12'h004, 64'hFF);
        wr(12'h000, 64'h1);
        rd(12'h000, a, b); chk("R3 run readback", a, 1);
        pulse('h11, 3); pulse('h33, 2); pulse('h66, 5); pulse('h88, 1);
        rd(cnt_off(0), a, b); chk("R2 counter0 lane0", a, 3);
        rd(cnt_off(2), a, b); chk("R2 counter2 lane2", a, 2);
        rd(cnt_off(5), a, b); chk("R2 counter5 second select", a, 5);
        rd(cnt_off(7), a, b); chk("R2 counter7 lane3", a, 1);
        rd(cnt_off(1), a, b); chk("R2 counter1 untouched", a, 0);
    endtask

    task automatic t_enable();
        logic [63:0] a, b;
        wr(12'h000, 64'h0);
        pulse('h11, 4);
        rd(cnt_off(0), a, b); chk("R3 halt holds counter0", a, 3);
        wr(12'h000, 64'h1);
        wr(12'h004, 64'hFE);
        pulse('h11, 1);
        rd(cnt_off(0), a, b); chk("R3 disabled counter0", a, 3);
        pulse('h22, 2);
        rd(cnt_off(1), a, b); chk("R3 enabled counter1", a, 2);
        wr(12'h004, 64'hFF);
    endtask

    task automatic t_write_prio();
        logic [63:0] a, b;
        @(negedge clk);
        evt['h44] = 1'b1; bus_we = 1'b1; bus_addr = cnt_off(3); bus_wdata = 64'd100;
        @(negedge clk);
        evt['h44] = 1'b0; bus_we = 1'b0;
        rd(cnt_off(3), a, b); chk("R4 write beats increment", a, 100);
        pulse('h44, 1);
        rd(cnt_off(3), a, b); chk("R4 counts on from written value", a, 101);
    endtask

    task automatic t_overflow();
        logic [63:0] a, b;
        wr(cnt_off(4), 64'hFFFF_FFFF_FFFF_FFFE);
        pulse('h55, 1);
        rd(12'h024, a, b); chk("R5 no status before wrap", a, 0);
        rd(cnt_off(4), a, b); chk("R4 64-bit value", a, 64'hFFFF_FFFF_FFFF_FFFF);
        pulse('h55, 1);
        rd(cnt_off(4), a, b); chk("R5 wrapped to zero", a, 0);
        rd(12'h024, a, b); chk("R5 status bit4", a, 64'h10);
        chk("R6 masked irq low", {63'b0, irq0}, 0);
        wr(12'h020, 64'hEF);
        chk("R6 unmasked irq high", {63'b0, irq0}, 1);
        wr(12'h020, 64'hFF);
        chk("R6 remasked irq low", {63'b0, irq0}, 0);
        wr(12'h020, 64'hEF);
    endtask

    task automatic t_clear();
        logic [63:0] a, b;
        wr(12'h024, 64'h10);
        rd(12'h024, a, b);
        chk("R7 split style ignores status write", a, 64'h10);
        chk("R7 self-clearing style clears", b, 0);
        chk("R7 split irq still high", {63'b0, irq0}, 1);
        chk("R7 self-clearing irq low", {63'b0, irq1}, 0);
        wr(12'h028, 64'h10);
        rd(12'h024, a, b); chk("R7 clear register clears", a, 0);
        chk("R7 irq low after clear", {63'b0, irq0}, 0);
    endtask

    task automatic t_filter();
        logic [63:0] a, b;
        wr(cnt_off(0), 64'd0);
        wr(12'h010, 64'((11'h00F << 12) | (1 << 11) | 11'h123));
        src_id = 11'h12A; pulse('h11, 2);
        src_id = 11'h133; pulse('h11, 3);
        rd(cnt_off(0), a, b); chk("R8 source match under mask", a, 2);
        wr(12'h010, 64'h0);
        pulse('h11, 1);
        rd(cnt_off(0), a, b); chk("R8 zero write disables", a, 3);
        wr(12'h00C, 64'((1 << 11) | 11'h7FF));
        tgt_id = 11'h7FF; pulse('h11, 1);
        tgt_id = 11'h7FE; pulse('h11, 2);
        rd(cnt_off(0), a, b); chk("R8 target exact match", a, 4);
        wr(12'h00C, 64'h0);
    endtask

    task automatic t_tag();
        logic [63:0] a, b;
        wr(12'h008, 64'h10);
        rd(12'h008, a, b); chk("R9 tag enable readback", a, 64'h10);
        tag = 1'b1; pulse('h11, 1);
        tag = 1'b0; pulse('h11, 2);
        rd(cnt_off(0), a, b); chk("R9 only tagged pulses", a, 5);
        wr(12'h008, 64'h0);
    endtask

    task automatic t_misc();
        logic [63:0] a, b;
        rd(12'h07C, a, b); chk("R10 identifier", a, 64'h0B17);
        wr(12'h07C, 64'hDEAD);
        rd(12'h07C, a, b); chk("R10 identifier write ignored", a, 64'h0B17);
        rd(12'h300, a, b); chk("R11 unmapped reads zero", a, 0);
        rd(12'h028, a, b); chk("R11 clear register reads zero", a, 0);
        rd(cnt_off(5), a, b);
        @(negedge clk);
        chk("R11 read data held", rdata0, 5);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_select();
        t_enable();
        t_write_prio();
        t_overflow();
        t_clear();
        t_filter();
        t_tag();
        t_misc();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule